// File: doc/BRIEF.md
# Time-of-Day Alarm Match and Interrupt Flag Unit

This block sits beside a real-time clock counter. It holds three alarm bytes for seconds, minutes and hours. On each once-per-second compare strobe it checks them against the running time. An alarm byte whose two top bits are both set is a wildcard and matches any value of its field. When every field matches on a strobe, an alarm event is raised.

The alarm event, a periodic-rate pulse and an update-ended pulse each set a sticky flag in a status byte. A summary bit in that byte is high while any flag is set together with its enable. The active-low interrupt line follows the summary bit. When the host reads the status byte, all flags clear at the end of the read cycle. An event that arrives in that same cycle survives the clear.

The reset input is asynchronous and active low. Its release is synchronized to the clock over two stages.

Top module: `alrm_irq_top`

## Requirements
- R1: A host write with `wr_en_i` high loads `wr_data_i` into the seconds alarm at address 1, the minutes alarm at address 3 and the hours alarm at address 5. A write to any other address leaves all three alarms unchanged.
- R2: If `tick_i` is high in a cycle and all three time fields match their alarms, flag bit 5 (alarm) of `flag_o` is set from the next cycle on. It stays set until it is read.
- R3: An alarm byte whose bits 7:6 are both 1 (0xC0..0xFF) matches any time value. An alarm byte of 0xBF or below matches only an equal value.
- R4: No alarm flag is raised while `tick_i` is low. No alarm flag is raised when any single field differs from its alarm.
- R5: A `per_evt_i` pulse sets flag bit 6 and an `upd_evt_i` pulse sets flag bit 4, both visible from the next cycle.
- R6: The event flags in bits 6..4 are set whatever the state of the enables.
- R7: Flag bit 7 equals the OR of bit 6 AND `irq_en_i[2]`, bit 5 AND `irq_en_i[1]`, and bit 4 AND `irq_en_i[0]`. It follows changes of the enables in the same cycle.
- R8: `irq_no` is the inverse of flag bit 7.
- R9: A cycle with `flag_rd_i` high presents the current flags on `flag_o` and clears bits 6..4 at the next edge. Bits 3..0 always read 0.
- R10: An event that arrives in the same cycle as a read is set after the clear, so the next read shows it.
- R11: While the reset is active, and after it, the flags read 0, `irq_no` is 1 and all alarms hold 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Host write strobe for the alarm bytes |
| wr_addr_i | input | 4 | Host write address |
| wr_data_i | input | 8 | Host write data |
| sec_i | input | 8 | Current seconds |
| min_i | input | 8 | Current minutes |
| hour_i | input | 8 | Current hours |
| tick_i | input | 1 | Once-per-second compare strobe |
| per_evt_i | input | 1 | Periodic event pulse |
| upd_evt_i | input | 1 | Update-ended event pulse |
| irq_en_i | input | 3 | Enables {periodic, alarm, update-ended} |
| flag_rd_i | input | 1 | Host read strobe for the status byte |
| flag_o | output | 8 | Status byte: 7 summary, 6 periodic, 5 alarm, 4 update-ended |
| irq_no | output | 1 | Active-low interrupt request |

## Verification
The compare logic is driven with four kinds of input. A full match with a wildcard hour checks that the wildcard works. A mismatch in the seconds field alone and in the minutes field alone shows that each field takes part in the compare. A match presented without the strobe shows that the strobe gates the event. A boundary pair, 0xBF against 0xC0, sets apart the lowest wildcard value from the highest exact value. Flag tests step the enables one at a time over a fixed set of pending flags, which shows that only the summary bit depends on them. Reads are applied both alone and together with events, which tells a plain clear apart from a clear that keeps a new event.

// File: rtl/alrm_irq_pkg.sv
package alrm_irq_pkg;
  localparam int BYTE_W  = 8;
  localparam int FIELD_N = 3;
  localparam int BIT_SUM = 7;
  localparam int BIT_PER = 6;
  localparam int BIT_ALM = 5;
  localparam int BIT_UPD = 4;

  typedef struct packed {
    logic per;
    logic alm;
    logic upd;
  } evt_t;

  function automatic logic is_wild(input logic [BYTE_W-1:0] v);
    return &v[BYTE_W-1 -: 2];
  endfunction
endpackage

// File: rtl/alrm_rst_sync.sv
module alrm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= pipe_d;
  end

  assign rst_no = pipe_q[STAGES-1];
endmodule

// File: rtl/alrm_field_match.sv
module alrm_field_match
  import alrm_irq_pkg::*;
(
  input  logic [BYTE_W-1:0] alarm_i,
  input  logic [BYTE_W-1:0] now_i,
  output logic              hit_o
);
  always_comb begin
    hit_o = is_wild(alarm_i) || (alarm_i == now_i);
  end
endmodule

// File: rtl/alrm_compare.sv
module alrm_compare
  import alrm_irq_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_en_i,
  input  logic [ADDR_W-1:0]              wr_addr_i,
  input  logic [BYTE_W-1:0]              wr_data_i,
  input  logic [FIELD_N-1:0][BYTE_W-1:0] now_i,
  input  logic                           tick_i,
  output logic                           alm_evt_o
);
  logic [FIELD_N-1:0] hit;

  for (genvar g = 0; g < FIELD_N; g++) begin : g_field
    localparam logic [ADDR_W-1:0] SLOT = ADDR_W'(2 * g + 1);
    logic              load_en;
    logic [BYTE_W-1:0] alarm_d;
    logic [BYTE_W-1:0] alarm_q;

    always_comb begin
      load_en = wr_en_i && (wr_addr_i == SLOT);
      alarm_d = load_en ? wr_data_i : alarm_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) alarm_q <= '0;
      else         alarm_q <= alarm_d;
    end

    alrm_field_match u_match (
      .alarm_i (alarm_q),
      .now_i   (now_i[g]),
      .hit_o   (hit[g])
    );
  end

  always_comb begin
    alm_evt_o = tick_i && (&hit);
  end
endmodule

// File: rtl/alrm_flag_reg.sv
module alrm_flag_reg
  import alrm_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  evt_t              evt_i,
  input  evt_t              en_i,
  input  logic              rd_i,
  output logic [BYTE_W-1:0] flag_o,
  output logic              req_o
);
  logic [2:0] flags_q;
  logic [2:0] flags_d;
  logic [2:0] kept;

  always_comb begin
    kept    = rd_i ? 3'b000 : flags_q;
    flags_d = kept | evt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= flags_d;
  end

  always_comb begin
    req_o                     = |(flags_q & en_i);
    flag_o                    = '0;
    flag_o[BIT_SUM]           = req_o;
    flag_o[BIT_PER:BIT_UPD]   = flags_q;
  end
endmodule

// File: rtl/alrm_irq_top.sv
module alrm_irq_top
  import alrm_irq_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [7:0]        sec_i,
  input  logic [7:0]        min_i,
  input  logic [7:0]        hour_i,
  input  logic              tick_i,
  input  logic              per_evt_i,
  input  logic              upd_evt_i,
  input  logic [2:0]        irq_en_i,
  input  logic              flag_rd_i,
  output logic [7:0]        flag_o,
  output logic              irq_no
);
  logic                           rst_n_sync;
  logic [FIELD_N-1:0][BYTE_W-1:0] now;
  logic                           alm_evt;
  logic                           req;
  evt_t                           evt;
  evt_t                           en;

  alrm_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_sync)
  );

  always_comb begin
    now[0] = sec_i;
    now[1] = min_i;
    now[2] = hour_i;
  end

  alrm_compare #(.ADDR_W(ADDR_W)) u_cmp (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_sync),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .now_i     (now),
    .tick_i    (tick_i),
    .alm_evt_o (alm_evt)
  );

  always_comb begin
    evt.per = per_evt_i;
    evt.alm = alm_evt;
    evt.upd = upd_evt_i;
    en      = evt_t'(irq_en_i);
  end

  alrm_flag_reg u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_n_sync),
    .evt_i  (evt),
    .en_i   (en),
    .rd_i   (flag_rd_i),
    .flag_o (flag_o),
    .req_o  (req)
  );

  assign irq_no = ~req;
endmodule

// File: rtl/alrm_irq_chk.sv
module alrm_irq_chk (
  input logic       clk_i,
  input logic       rst_n,
  input logic       tick_i,
  input logic       per_evt_i,
  input logic       upd_evt_i,
  input logic [2:0] irq_en_i,
  input logic       flag_rd_i,
  input logic [7:0] flag_o,
  input logic       irq_no
);
  assert_irq_mirror_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    irq_no != flag_o[7]);

  assert_summary_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    flag_o[7] == |(flag_o[6:4] & irq_en_i));

  assert_per_set_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    per_evt_i |=> flag_o[6]);

  assert_upd_set_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    upd_evt_i |=> flag_o[4]);

  assert_read_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
    (flag_rd_i && !tick_i && !per_evt_i && !upd_evt_i) |=> (flag_o[6:4] == 3'b000));

  assert_low_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
    flag_o[3:0] == 4'h0);

  assert_keep_on_read_R10: assert property (@(posedge clk_i) disable iff (!rst_n)
    (flag_rd_i && per_evt_i) |=> flag_o[6]);

  assert_no_tick_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!tick_i && !flag_o[5]) |=> !flag_o[5]);

  assert_alarm_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
    (flag_o[5] && !flag_rd_i) |=> flag_o[5]);
endmodule

bind alrm_irq_top alrm_irq_chk chk_i (
  .clk_i     (clk_i),
  .rst_n     (rst_n_sync),
  .tick_i    (tick_i),
  .per_evt_i (per_evt_i),
  .upd_evt_i (upd_evt_i),
  .irq_en_i  (irq_en_i),
  .flag_rd_i (flag_rd_i),
  .flag_o    (flag_o),
  .irq_no    (irq_no)
);

// File: tb/alrm_irq_top_tb_top.sv
module alrm_irq_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] sec = '0, mins = '0, hour = '0;
  logic       tick = 1'b0, per = 1'b0, upd = 1'b0, rd = 1'b0;
  logic [2:0] en = '0;
  logic [7:0] flag;
  logic       irq_n;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  alrm_irq_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .sec_i(sec), .min_i(mins), .hour_i(hour),
    .tick_i(tick), .per_evt_i(per), .upd_evt_i(upd), .irq_en_i(en),
    .flag_rd_i(rd), .flag_o(flag), .irq_no(irq_n)
  );

  // sec, min, hour, tick, per, upd, rd, en{per,alm,upd}, expected flag byte
  localparam int NV = 14;
  localparam logic [38:0] VEC [NV] = '{
    {8'h30, 8'h15, 8'h08, 1'b1, 1'b0, 1'b0, 1'b0, 3'b000, 8'h20}, // R2 R3 R6
    {8'h30, 8'h15, 8'h08, 1'b0, 1'b0, 1'b0, 1'b0, 3'b010, 8'hA0}, // R7
    {8'h30, 8'h15, 8'h08, 1'b0, 1'b0, 1'b0, 1'b1, 3'b010, 8'h00}, // R9
    {8'h31, 8'h15, 8'h08, 1'b1, 1'b0, 1'b0, 1'b0, 3'b010, 8'h00}, // R4 sec differs
    {8'h30, 8'h16, 8'h08, 1'b1, 1'b0, 1'b0, 1'b0, 3'b010, 8'h00}, // R4 min differs
    {8'h30, 8'h15, 8'h08, 1'b0, 1'b0, 1'b0, 1'b0, 3'b010, 8'h00}, // R4 no tick
    {8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 3'b000, 8'h40}, // R5 R6
    {8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 3'b000, 8'h50}, // R5
    {8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 3'b001, 8'hD0}, // R7
    {8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 3'b100, 8'hD0}, // R7
    {8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 3'b010, 8'h50}, // R7
    {8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 3'b100, 8'hC0}, // R10
    {8'h30, 8'h15, 8'h08, 1'b1, 1'b0, 1'b1, 1'b1, 3'b100, 8'h30}, // R10
    {8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 3'b111, 8'h00}  // R9
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic write_alarm(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic step(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                      input logic t, input logic p, input logic u, input logic r,
                      input logic [2:0] e);
    sec = s; mins = m; hour = h; tick = t; per = p; upd = u; rd = r; en = e;
    @(posedge clk); @(negedge clk);
    tick = 1'b0; per = 1'b0; upd = 1'b0; rd = 1'b0;
  endtask

  task automatic clear_flags();
    step(8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 3'b000);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 flags in reset", flag, 8'h00);
    check("R11 irq in reset", {7'b0, irq_n}, 8'h01);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R11 flags after reset", flag, 8'h00);
    check("R8 irq idle", {7'b0, irq_n}, 8'h01);

    // R11: alarms reset to 0x00, so time 00:00:00 matches
    step(8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 3'b000);
    check("R11 alarm reset value", flag, 8'h20);
    clear_flags();

    // R1: load alarms; hour is a wildcard (R3)
    write_alarm(4'd1, 8'h30);
    write_alarm(4'd3, 8'h15);
    write_alarm(4'd5, 8'hC5);

    for (int i = 0; i < NV; i++) begin
      logic [38:0] v;
      v = VEC[i];
      step(v[38:31], v[30:23], v[22:15], v[14], v[13], v[12], v[11], v[10:8]);
      check($sformatf("vector %0d flag", i), flag, v[7:0]);
      check($sformatf("R8 vector %0d irq", i), {7'b0, irq_n}, {7'b0, ~v[7]});
    end

    // R1: writes to other addresses leave the alarms alone
    write_alarm(4'd0, 8'h99);
    write_alarm(4'd2, 8'h99);
    write_alarm(4'd4, 8'h99);
    write_alarm(4'd6, 8'h99);
    step(8'h30, 8'h15, 8'h08, 1'b1, 1'b0, 1'b0, 1'b0, 3'b010);
    check("R1 other addresses ignored", flag, 8'hA0);
    check("R8 irq asserted", {7'b0, irq_n}, 8'h00);
    clear_flags();

    // R3 boundary: 0xBF is exact, 0xC0 is wildcard
    write_alarm(4'd1, 8'hBF);
    step(8'h3F, 8'h15, 8'h08, 1'b1, 1'b0, 1'b0, 1'b0, 3'b000);
    check("R3 0xBF is not wildcard", flag, 8'h00);
    step(8'hBF, 8'h15, 8'h08, 1'b1, 1'b0, 1'b0, 1'b0, 3'b000);
    check("R3 0xBF exact match", flag, 8'h20);
    clear_flags();
    write_alarm(4'd1, 8'hC0);
    step(8'h59, 8'h15, 8'h23, 1'b1, 1'b0, 1'b0, 1'b0, 3'b000);
    check("R3 0xC0 wildcard", flag, 8'h20);

    // R6: flags stay set with all enables off; R11 async reset clears them
    step(8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 3'b000);
    check("R6 flags with enables off", flag, 8'h70);
    en = 3'b111;
    #1;
    check("R7 summary follows enable", flag, 8'hF0);
    rst_n = 1'b0;
    #1;
    check("R11 async reset clears flags", flag, 8'h00);
    check("R11 async reset irq", {7'b0, irq_n}, 8'h01);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    step(8'h59, 8'h15, 8'h23, 1'b1, 1'b0, 1'b0, 1'b0, 3'b000);
    check("R11 alarms back to 0x00", flag, 8'h00);

    done = 1'b1;
    finish_run();
  end
endmodule